// File: doc/BRIEF.md
# Double-Precision to Signed 32-bit Integer Converter

This block takes a 64-bit IEEE-754 double-precision operand and turns it into a signed 32-bit integer. The caller picks the rounding with a 2-bit mode input. A separate truncate input forces round-toward-zero no matter what the mode input carries. Operands that cannot be represented are clamped to a fixed integer pattern and reported as invalid conversions: a NaN, either infinity, or a finite value outside the signed 32-bit range. Signalling NaNs raise one extra flag.

The integer is returned inside a 64-bit destination image. The upper word of that image holds a constant tag. One extra bit marks a zero result that came from a negative operand. The block also reports two rounding flags: an inexact flag, and a flag that says the magnitude was increased. It raises a pulse that sets the sticky inexact summary. It produces a write enable for the destination register, which is withheld when an invalid conversion occurs while invalid-operation traps are enabled.

Results appear one clock after the operand is presented. The status register, the condition register and the result-class field belong to the surrounding unit, and this block does not touch them.

Top module: `dbl_to_int_conv`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high for exactly the following cycle and carries that operand's result. When `out_valid` is low, `out_wr_en`, `out_inv_cvt`, `out_inv_snan`, `out_fi`, `out_fr` and `out_xx_set` are all low.
- R2: The rounding mode is encoded as 2'b00 round to nearest, 2'b01 toward zero, 2'b10 toward +infinity and 2'b11 toward -infinity. When `force_trunc` is 1, the block rounds toward zero whatever `rmode` holds.
- R3: A NaN operand (exponent all ones, fraction nonzero) yields integer 0x80000000 and sets `out_inv_cvt`. The operand is a signalling NaN when fraction bit 51 is also 0. In that case `out_inv_snan` is set as well, and it is never set otherwise.
- R4: A non-NaN operand greater than 2147483647 yields 0x7FFFFFFF and sets `out_inv_cvt`. This includes +infinity and non-integers between 2147483647 and 2147483648.
- R5: A non-NaN operand less than -2147483648 yields 0x80000000 and sets `out_inv_cvt`, and this includes -infinity. The operand -2147483648.0 itself converts exactly and is valid.
- R6: On any invalid conversion, `out_fi`, `out_fr` and `out_xx_set` are all 0.
- R7: For an in-range operand, an exact conversion leaves `out_fi`, `out_fr` and `out_xx_set` at 0. An inexact one sets `out_fi` and `out_xx_set`. `out_fr` is set only when the magnitude of the integer is larger than the magnitude of the operand.
- R8: In round-to-nearest mode, an operand exactly halfway between two integers goes to the even one.
- R9: `out_image` is 0xFFF80000_00000000 ORed with the 32-bit integer. Bit 32 is also set when the integer is zero and the operand's sign bit (bit 63) is 1.
- R10: `out_wr_en` is high for a valid result unless that result is an invalid conversion and `inv_enable` was 1 when the operand was presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 64 | IEEE-754 double operand |
| rmode | input | 2 | Rounding mode (see R2) |
| force_trunc | input | 1 | Force round toward zero |
| inv_enable | input | 1 | Invalid-operation trap enable |
| out_valid | output | 1 | Result valid |
| out_image | output | 64 | Packed destination image |
| out_wr_en | output | 1 | Destination write enable |
| out_inv_cvt | output | 1 | Invalid-convert flag |
| out_inv_snan | output | 1 | Signalling-NaN invalid flag |
| out_fi | output | 1 | Fraction inexact |
| out_fr | output | 1 | Fraction rounded up in magnitude |
| out_xx_set | output | 1 | Set pulse for the sticky inexact summary |

## Verification
The checker watches the following on every cycle:
- the one-cycle latency and the quiet flags between results;
- that an invalid conversion always carries one of the two saturation words and never carries a rounding flag;
- that `out_fr` never appears without `out_fi`;
- that a signalling-NaN flag never appears without the invalid flag;
- the constant tag in the upper word, and that the negative-zero marker appears only on a zero integer;
- the write gating by the trap enable.

Only the bench's directed operands can show that the integer value itself is right. This covers each rounding direction, ties going to even, and the exact edges of the range on both sides: 2147483647, 2147483647.5, -2147483648 and -2147483648.5. It also covers subnormals, and the exact way truncation overrides the mode.

// File: rtl/dti_pkg.sv
// Shared constants and types for the double-to-int32 converter.
// Assumes IEEE-754 binary64 operands and a 32-bit signed result.
package dti_pkg;
    localparam int DBL_W   = 64;
    localparam int EXP_W   = 11;
    localparam int FRC_W   = 52;
    localparam int INT_W   = 32;
    localparam int BIAS    = 1023;
    localparam int SIG_W   = FRC_W + 1;
    localparam int SH_W    = $clog2(SIG_W);
    localparam int TAG_W   = DBL_W - INT_W;
    localparam logic [TAG_W-1:0] IMG_TAG = 32'hFFF8_0000;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_POS  = 2'b10,
        RM_NEG  = 2'b11
    } rmode_e;
endpackage

// File: rtl/dti_unpack.sv
// Splits a double into sign, class and an integer part plus guard/sticky bits.
// Assumes the integer part is only meaningful when the unbiased exponent is 0..31;
// larger finite values and infinities are reported through 'huge'.
module dti_unpack
    import dti_pkg::*;
(
    input  logic [DBL_W-1:0] op,
    output logic             sign,
    output logic             is_nan,
    output logic             is_snan,
    output logic             huge,
    output logic             exp_is_top,
    output logic [INT_W-1:0] ipart,
    output logic             guard,
    output logic             sticky
);
    localparam logic [EXP_W-1:0] EXP_ALL1 = '1;
    localparam int EXP_LIM = INT_W - 1;
    localparam logic signed [EXP_W+1:0] BIAS_S = (EXP_W+2)'(BIAS);

    logic [EXP_W-1:0]          bexp;
    logic [FRC_W-1:0]          frac;
    logic [SIG_W-1:0]          sig;
    logic signed [EXP_W+1:0]   uexp;
    logic [SH_W-1:0]           sh;

    assign sign    = op[DBL_W-1];
    assign bexp    = op[DBL_W-2:FRC_W];
    assign frac    = op[FRC_W-1:0];
    assign sig     = {|bexp, frac};
    assign uexp    = $signed({2'b00, bexp}) - BIAS_S;
    assign is_nan  = (bexp == EXP_ALL1) && (frac != '0);
    assign is_snan = is_nan && !frac[FRC_W-1];

    // Align the significand to the binary point and collect the rounding bits.
    always_comb begin
        ipart      = '0;
        guard      = 1'b0;
        sticky     = 1'b0;
        huge       = 1'b0;
        exp_is_top = 1'b0;
        sh         = '0;
        if (bexp == EXP_ALL1) begin
            huge = (frac == '0);
        end else if (uexp > EXP_LIM) begin
            huge = 1'b1;
        end else if (uexp >= 0) begin
            sh         = SH_W'(FRC_W) - SH_W'(uexp);
            ipart      = INT_W'(sig >> sh);
            guard      = sig[sh - 1'b1];
            sticky     = |(sig & ((SIG_W'(1) << (sh - 1'b1)) - SIG_W'(1)));
            exp_is_top = (uexp == EXP_LIM);
        end else if (uexp == -1) begin
            guard  = 1'b1;
            sticky = |frac;
        end else begin
            sticky = |op[DBL_W-2:0];
        end
    end
endmodule

// File: rtl/dti_round.sv
// Applies the rounding mode to a magnitude with guard/sticky bits and
// returns the two's-complement integer. Assumes the caller filters overflow.
module dti_round
    import dti_pkg::*;
(
    input  logic             sign,
    input  rmode_e           mode,
    input  logic [INT_W-1:0] ipart,
    input  logic             guard,
    input  logic             sticky,
    output logic [INT_W-1:0] value,
    output logic             inexact,
    output logic             bumped
);
    logic [INT_W-1:0] mag;

    // Decide whether the magnitude moves up to the next integer.
    always_comb begin
        inexact = guard | sticky;
        unique case (mode)
            RM_NEAR: bumped = guard & (sticky | ipart[0]);
            RM_ZERO: bumped = 1'b0;
            RM_POS:  bumped = inexact & !sign;
            RM_NEG:  bumped = inexact & sign;
            default: bumped = 1'b0;
        endcase
    end

    // Add the increment and apply the sign.
    always_comb begin
        mag   = ipart + INT_W'(bumped);
        value = sign ? (~mag + INT_W'(1)) : mag;
    end
endmodule

// File: rtl/dti_pack.sv
// Detects range and NaN violations, selects the saturated or rounded word,
// builds the tagged 64-bit image, the status flags and the write enable.
module dti_pack
    import dti_pkg::*;
(
    input  logic             sign,
    input  logic             is_nan,
    input  logic             is_snan,
    input  logic             huge,
    input  logic             exp_is_top,
    input  logic [INT_W-1:0] ipart,
    input  logic [INT_W-1:0] value,
    input  logic             inexact,
    input  logic             bumped,
    input  logic             inv_enable,
    output logic [DBL_W-1:0] image,
    output logic             wr_en,
    output logic             inv_cvt,
    output logic             inv_snan,
    output logic             fi,
    output logic             fr,
    output logic             xx_set
);
    localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

    logic             pos_ovf;
    logic             neg_ovf;
    logic [INT_W-1:0] word;

    // Classify the operand against the signed 32-bit range.
    always_comb begin
        pos_ovf = !sign && !is_nan &&
                  (huge || exp_is_top || (ipart == INT_MAX && inexact));
        neg_ovf = sign && !is_nan &&
                  (huge || (exp_is_top && (ipart != INT_MIN || inexact)));
        inv_cvt  = is_nan | pos_ovf | neg_ovf;
        inv_snan = is_snan;
    end

    // Select the result word and the rounding flags.
    always_comb begin
        if (is_nan || neg_ovf)  word = INT_MIN;
        else if (pos_ovf)       word = INT_MAX;
        else                    word = value;
        fi     = !inv_cvt && inexact;
        fr     = !inv_cvt && bumped;
        xx_set = fi;
    end

    // Pack the image and gate the write.
    always_comb begin
        image = {IMG_TAG, word};
        if (word == '0 && sign) image[INT_W] = 1'b1;
        wr_en = !(inv_cvt && inv_enable);
    end
endmodule

// File: rtl/dbl_to_int_conv.sv
// Top of the double-to-int32 converter: one register stage after the
// combinational unpack/round/pack path. Assumes one operand per cycle at most.
module dbl_to_int_conv
    import dti_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DBL_W-1:0] operand,
    input  logic [1:0]       rmode,
    input  logic             force_trunc,
    input  logic             inv_enable,
    output logic             out_valid,
    output logic [DBL_W-1:0] out_image,
    output logic             out_wr_en,
    output logic             out_inv_cvt,
    output logic             out_inv_snan,
    output logic             out_fi,
    output logic             out_fr,
    output logic             out_xx_set
);
    rmode_e           eff_mode;
    logic             u_sign, u_nan, u_snan, u_huge, u_top, u_guard, u_sticky;
    logic [INT_W-1:0] u_ipart;
    logic [INT_W-1:0] r_value;
    logic             r_inexact, r_bumped;
    logic [DBL_W-1:0] p_image;
    logic             p_wr, p_inv, p_snan, p_fi, p_fr, p_xx;

    // Truncation override wins over the mode field.
    assign eff_mode = force_trunc ? RM_ZERO : rmode_e'(rmode);

    dti_unpack u_unpack (
        .op(operand), .sign(u_sign), .is_nan(u_nan), .is_snan(u_snan),
        .huge(u_huge), .exp_is_top(u_top), .ipart(u_ipart),
        .guard(u_guard), .sticky(u_sticky)
    );

    dti_round u_round (
        .sign(u_sign), .mode(eff_mode), .ipart(u_ipart), .guard(u_guard),
        .sticky(u_sticky), .value(r_value), .inexact(r_inexact), .bumped(r_bumped)
    );

    dti_pack u_pack (
        .sign(u_sign), .is_nan(u_nan), .is_snan(u_snan), .huge(u_huge),
        .exp_is_top(u_top), .ipart(u_ipart), .value(r_value),
        .inexact(r_inexact), .bumped(r_bumped), .inv_enable(inv_enable),
        .image(p_image), .wr_en(p_wr), .inv_cvt(p_inv), .inv_snan(p_snan),
        .fi(p_fi), .fr(p_fr), .xx_set(p_xx)
    );

    // Output register: flags pulse with valid, image holds between results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_image    <= '0;
            out_wr_en    <= 1'b0;
            out_inv_cvt  <= 1'b0;
            out_inv_snan <= 1'b0;
            out_fi       <= 1'b0;
            out_fr       <= 1'b0;
            out_xx_set   <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            if (in_valid) out_image <= p_image;
            out_wr_en    <= in_valid & p_wr;
            out_inv_cvt  <= in_valid & p_inv;
            out_inv_snan <= in_valid & p_snan;
            out_fi       <= in_valid & p_fi;
            out_fr       <= in_valid & p_fr;
            out_xx_set   <= in_valid & p_xx;
        end
    end
endmodule

// File: rtl/dti_checker.sv
// Cycle-level properties of the converter's ports, bound to the top module.
module dti_checker
    import dti_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             inv_enable,
    input logic             out_valid,
    input logic [DBL_W-1:0] out_image,
    input logic             out_wr_en,
    input logic             out_inv_cvt,
    input logic             out_inv_snan,
    input logic             out_fi,
    input logic             out_fr,
    input logic             out_xx_set
);
    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_wr_en | out_inv_cvt | out_inv_snan | out_fi | out_fr | out_xx_set)); // R1
    AST_SNAN_IS_INVALID: assert property (@(posedge clk) disable iff (!rst_n) out_inv_snan |-> out_inv_cvt); // R3
    AST_SATURATED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_inv_cvt |-> (out_image[INT_W-1:0] == 32'h7FFF_FFFF || out_image[INT_W-1:0] == 32'h8000_0000)); // R4
    AST_INVALID_NO_ROUND_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        out_inv_cvt |-> !out_fi && !out_fr && !out_xx_set); // R6
    AST_FR_NEEDS_FI: assert property (@(posedge clk) disable iff (!rst_n) out_fr |-> out_fi); // R7
    AST_IMAGE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_image[DBL_W-1:INT_W+1] == IMG_TAG[TAG_W-1:1]); // R9
    AST_NEGZ_ONLY_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_image[INT_W] |-> out_image[INT_W-1:0] == '0); // R9
    AST_WRITE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_wr_en == !(out_inv_cvt && $past(inv_enable))); // R10
endmodule

bind dbl_to_int_conv dti_checker u_dti_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inv_enable(inv_enable),
    .out_valid(out_valid), .out_image(out_image), .out_wr_en(out_wr_en),
    .out_inv_cvt(out_inv_cvt), .out_inv_snan(out_inv_snan), .out_fi(out_fi),
    .out_fr(out_fr), .out_xx_set(out_xx_set)
);

// File: tb/dbl_to_int_conv_tb_top.sv
module dbl_to_int_conv_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  rmode = 2'b00;
    logic        force_trunc = 1'b0;
    logic        inv_enable = 1'b0;
    logic        out_valid;
    logic [63:0] out_image;
    logic        out_wr_en, out_inv_cvt, out_inv_snan, out_fi, out_fr, out_xx_set;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbl_to_int_conv dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .rmode(rmode), .force_trunc(force_trunc), .inv_enable(inv_enable),
        .out_valid(out_valid), .out_image(out_image), .out_wr_en(out_wr_en),
        .out_inv_cvt(out_inv_cvt), .out_inv_snan(out_inv_snan), .out_fi(out_fi),
        .out_fr(out_fr), .out_xx_set(out_xx_set)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference built on real arithmetic.
    task automatic model(input logic [63:0] op, input logic [1:0] rm, input bit trunc, input bit ve,
                         output logic [63:0] img, output bit wr, output bit inv, output bit sn,
                         output bit fi, output bit fr);
        real b, f, d, r;
        logic [31:0] w;
        bit nan;
        nan = (op[62:52] == 11'h7FF) && (op[51:0] != 0);
        b = $bitstoreal(op);
        inv = 0; sn = 0; fi = 0; fr = 0;
        if (nan) begin
            w = 32'h8000_0000; inv = 1; sn = !op[51];
        end else if (b > 2147483647.0) begin
            w = 32'h7FFF_FFFF; inv = 1;
        end else if (b < -2147483648.0) begin
            w = 32'h8000_0000; inv = 1;
        end else begin
            f = $floor(b);
            d = b - f;
            if (trunc || rm == 2'b01) r = (b >= 0.0) ? f : $ceil(b);
            else if (rm == 2'b10) r = $ceil(b);
            else if (rm == 2'b11) r = f;
            else begin
                if (d > 0.5) r = f + 1.0;
                else if (d < 0.5) r = f;
                else r = ($rtoi(f) % 2 == 0) ? f : f + 1.0;
            end
            w = 32'($rtoi(r));
            fi = (r != b);
            fr = ((r < 0.0 ? -r : r) > (b < 0.0 ? -b : b));
        end
        img = {32'hFFF8_0000, w};
        if (w == 0 && op[63]) img[32] = 1'b1;
        wr = !(inv && ve);
    endtask

    // One operand: drive at a falling edge, result registered at the next
    // rising edge, sampled at the falling edge after it.
    task automatic run(input string req, input logic [63:0] op, input logic [1:0] rm,
                       input bit trunc, input bit ve);
        logic [63:0] e_img;
        bit e_wr, e_inv, e_sn, e_fi, e_fr;
        model(op, rm, trunc, ve, e_img, e_wr, e_inv, e_sn, e_fi, e_fr);
        @(negedge clk);
        operand = op; rmode = rm; force_trunc = trunc; inv_enable = ve; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "valid", 64'(out_valid), 64'd1);
        chk(req, "image", out_image, e_img);
        chk(req, "wr_en R10", 64'(out_wr_en), 64'(e_wr));
        chk(req, "inv_cvt", 64'(out_inv_cvt), 64'(e_inv));
        chk(req, "inv_snan", 64'(out_inv_snan), 64'(e_sn));
        chk(req, "fi", 64'(out_fi), 64'(e_fi));
        chk(req, "fr", 64'(out_fr), 64'(e_fr));
        chk(req, "xx_set", 64'(out_xx_set), 64'(e_fi));
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R1", "idle valid", 64'(out_valid), 64'd0);
        chk("R1", "idle flags",
            64'({out_wr_en, out_inv_cvt, out_inv_snan, out_fi, out_fr, out_xx_set}), 64'd0);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset valid", 64'(out_valid), 64'd0);
        chk("R1", "reset image", out_image, 64'd0);
        rst_n = 1'b1;
        idle_check();

        run("R7", 64'h3FF0_0000_0000_0000, 2'b00, 0, 0);        // 1.0 exact
        run("R8", 64'h4004_0000_0000_0000, 2'b00, 0, 0);        // 2.5 -> 2
        run("R8", 64'h400C_0000_0000_0000, 2'b00, 0, 0);        // 3.5 -> 4
        run("R8", 64'hC004_0000_0000_0000, 2'b00, 0, 0);        // -2.5 -> -2
        run("R8", 64'h3FE0_0000_0000_0000, 2'b00, 0, 0);        // 0.5 -> 0
        run("R2", 64'h4004_0000_0000_0000, 2'b10, 0, 0);        // 2.5 up -> 3
        run("R2", 64'hC004_0000_0000_0000, 2'b11, 0, 0);        // -2.5 down -> -3
        run("R2", 64'hC004_0000_0000_0000, 2'b10, 0, 0);        // -2.5 up -> -2
        run("R2", 64'h3FFC_0000_0000_0000, 2'b01, 0, 0);        // 1.75 trunc
        run("R2", 64'h3FFC_0000_0000_0000, 2'b10, 1, 0);        // forced trunc
        run("R2", 64'hBFFC_0000_0000_0000, 2'b11, 1, 0);        // forced trunc neg
        run("R9", 64'h8000_0000_0000_0000, 2'b00, 0, 0);        // -0.0
        run("R9", 64'hBFD0_0000_0000_0000, 2'b01, 0, 0);        // -0.25 -> 0 marker
        run("R9", 64'h0000_0000_0000_0000, 2'b00, 0, 0);        // +0.0
        run("R7", 64'h0000_0000_0000_0001, 2'b10, 0, 0);        // subnormal up -> 1
        run("R3", 64'h7FF8_0000_0000_0000, 2'b00, 0, 0);        // quiet NaN
        run("R3", 64'h7FF0_0000_0000_0001, 2'b00, 0, 0);        // signalling NaN
        run("R3", 64'hFFF4_0000_0000_0000, 2'b10, 0, 1);        // sNaN, trap on
        run("R4", 64'h7FF0_0000_0000_0000, 2'b00, 0, 0);        // +inf
        run("R4", 64'h41DF_FFFF_FFE0_0000, 2'b01, 0, 0);        // 2147483647.5
        run("R4", 64'h41DF_FFFF_FFC0_0000, 2'b00, 0, 0);        // 2147483647 exact
        run("R4", 64'h41E0_0000_0000_0000, 2'b00, 0, 1);        // 2^31, trap on
        run("R5", 64'hFFF0_0000_0000_0000, 2'b00, 0, 0);        // -inf
        run("R5", 64'hC1E0_0000_0000_0000, 2'b00, 0, 1);        // -2^31 valid
        run("R5", 64'hC1E0_0000_0010_0000, 2'b00, 0, 0);        // -2147483648.5
        run("R6", 64'hC1DF_FFFF_FFE0_0000, 2'b00, 0, 0);        // -2147483647.5 -> -2^31
        run("R10", 64'h7FF8_0000_0000_0000, 2'b00, 0, 1);       // NaN, trap on
        run("R10", 64'h4004_0000_0000_0000, 2'b00, 0, 1);       // inexact, trap on writes
        idle_check();

        for (int k = 0; k < 48; k++) begin
            real v;
            v = (real'(k) - 24.0) * 98765.4321 / 7.0 + real'(k % 3) * 0.5;
            run("R7", $realtobits(v), 2'(k), (k % 5) == 0, (k % 2) == 1);
        end
        idle_check();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule